// File: doc/BRIEF.md
# External Event Counter Timer Channel

This block is one 16-bit timer channel that counts transitions on an external event input. A pulse on the interrupt output marks each completed group of events. The input is passed through a two-flop synchronizer. A 2-bit edge-select field chooses whether rising edges, falling edges or both count as events. Software works the channel through a small single-cycle register port, using self-clearing start and stop triggers.

On start, the counter takes the value of the reload register and waits for events. Each event decrements the counter. An event that arrives while the counter is zero reloads it and counting goes on. With a reload value N, the interrupt fires once every N+1 events in steady state. While the channel runs, the mode register is locked. While the unit enable is low, every channel register is held cleared and only the unit enable itself can be written.

The control sequence is a three-state machine:
- `S_OFF`: the unit is disabled.
- `S_IDLE`: the unit is enabled and the channel is stopped.
- `S_RUN`: the channel is counting.

Its transitions are:
- power-up (`S_OFF`→`S_IDLE` when the unit enable is set)
- start (`S_IDLE`→`S_RUN`)
- restart (`S_RUN`→`S_RUN`, reloading the counter)
- stop (`S_RUN`→`S_IDLE`)
- shutdown (any state →`S_OFF` while the unit enable is clear)

Top module: `evcnt_channel`

Register map (3-bit address, 16-bit data):
- 0: unit enable, bit 0.
- 1: mode. The edge select is in bits [1:0]: 00 rising, 01 falling, 10 or 11 both. The output-enable bit is bit 4.
- 2: reload value.
- 3: counter, read only.
- 4: triggers. Bit 0 is start and bit 1 is stop. Each bit reads 1 only during the cycle after it is written.
- 5: status. Bit 0 is set while the channel is running.

## Requirements
- R1: After the active-low reset, every register at addresses 0 to 5 reads 0 and the interrupt output is 0.
- R2: Writing 1 to bit 0 at address 4 sets status bit 0 and loads the counter from the reload register. The trigger bit reads 0 from the second cycle after the write.
- R3: While running, the counter decrements by one for each detected event. The edge select in mode bits [1:0] decides what counts: 00 rising, 01 falling, 10 or 11 both edges.
- R4: An event seen while the counter is 0 reloads it from the reload register. A one-cycle interrupt pulse marks each event that leaves the counter at 0. After k events from a start with reload N, the counter reads N − (k mod (N+1)) and floor((k+1)/(N+1)) pulses have occurred, less one when N is 0.
- R5: Writing 1 to bit 1 at address 4 clears status bit 0. The counter then holds its value while further events arrive.
- R6: The reload register can be written while running without changing the counter. The new value is used at the next reload.
- R7: While the channel runs, writes to the mode register (address 1) are ignored.
- R8: While the unit enable is 0, all other registers read 0 and writes to them are ignored.
- R9: When start and stop are written together, stop wins and the channel does not run.
- R10: A start written while running reloads the counter from the reload register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ev_in | input | 1 | Asynchronous external event input |
| bus_addr | input | 3 | Register address |
| bus_we | input | 1 | Write enable, one write per cycle |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data for bus_addr, combinational |
| irq_o | output | 1 | One-cycle interrupt pulse |

## Verification
A wrong state-machine state shows at the status register in the very next read. A state stuck in `S_OFF` also zeroes the counter readback. A corrupted counter or wrong reload behaviour shows as a mismatched counter reading within three cycles of the event that caused it. It also appears as a pulse count that departs from floor((k+1)/(N+1)) within one reload period. The sweep covers every edge mode with reload values 0 to 4, so off-by-one errors at the zero boundary show in the first reload period.

// File: rtl/evcnt_pkg.sv
package evcnt_pkg;

    localparam int ADDR_W = 3;

    localparam logic [ADDR_W-1:0] A_UNIT   = 3'd0;
    localparam logic [ADDR_W-1:0] A_MODE   = 3'd1;
    localparam logic [ADDR_W-1:0] A_RELOAD = 3'd2;
    localparam logic [ADDR_W-1:0] A_COUNT  = 3'd3;
    localparam logic [ADDR_W-1:0] A_TRIG   = 3'd4;
    localparam logic [ADDR_W-1:0] A_STATUS = 3'd5;

    localparam int MODE_OE_BIT = 4;

    typedef enum logic [1:0] {
        EDGE_RISE = 2'b00,
        EDGE_FALL = 2'b01,
        EDGE_BOTH = 2'b10,
        EDGE_ALT  = 2'b11
    } edge_sel_e;

    typedef enum logic [1:0] {
        S_OFF  = 2'b00,
        S_IDLE = 2'b01,
        S_RUN  = 2'b10
    } chan_state_e;

endpackage

// File: rtl/evcnt_edge_detect.sv
module evcnt_edge_detect
    import evcnt_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            ev_in,
    input  edge_sel_e       edge_sel,
    output logic            hit
);

    logic [SYNC_STAGES-1:0] sync_q;
    logic                   last_q;
    logic                   cur;
    logic                   rose;
    logic                   fell;

    generate
        for (genvar i = 0; i < SYNC_STAGES; i++) begin : g_sync
            if (i == 0) begin : g_first
                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n) sync_q[0] <= 1'b0;
                    else        sync_q[0] <= ev_in;
                end
            end else begin : g_next
                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n) sync_q[i] <= 1'b0;
                    else        sync_q[i] <= sync_q[i-1];
                end
            end
        end
    endgenerate

    assign cur = sync_q[SYNC_STAGES-1];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) last_q <= 1'b0;
        else        last_q <= cur;
    end

    assign rose = cur & ~last_q;
    assign fell = ~cur & last_q;

    always_comb begin
        unique case (edge_sel)
            EDGE_RISE: hit = rose;
            EDGE_FALL: hit = fell;
            EDGE_BOTH: hit = rose | fell;
            EDGE_ALT:  hit = rose | fell;
            default:   hit = 1'b0;
        endcase
    end

endmodule

// File: rtl/evcnt_ctrl_fsm.sv
module evcnt_ctrl_fsm
    import evcnt_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             unit_on,
    input  logic             start_req,
    input  logic             stop_req,
    input  logic             hit,
    input  logic [CNT_W-1:0] reload,
    output logic [CNT_W-1:0] count,
    output logic             chan_on,
    output logic             irq
);

    localparam logic [CNT_W-1:0] ZERO = '0;
    localparam logic [CNT_W-1:0] ONE  = CNT_W'(1);

    chan_state_e state_q, state_d;
    logic        do_start;

    assign do_start = start_req & ~stop_req;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= S_OFF;
        else        state_q <= state_d;
    end

    // transitions
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            S_OFF:  state_d = unit_on ? S_IDLE : S_OFF;
            S_IDLE: begin
                if (!unit_on)      state_d = S_OFF;
                else if (do_start) state_d = S_RUN;
            end
            S_RUN: begin
                if (!unit_on)      state_d = S_OFF;
                else if (stop_req) state_d = S_IDLE;
            end
            default: state_d = S_OFF;
        endcase
    end

    // outputs: counter and interrupt
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            count <= ZERO;
            irq   <= 1'b0;
        end else if (!unit_on || state_q == S_OFF) begin
            count <= ZERO;
            irq   <= 1'b0;
        end else begin
            irq <= 1'b0;
            if (do_start) begin
                count <= reload;
            end else if (state_q == S_RUN && !stop_req && hit) begin
                if (count == ZERO) begin
                    count <= reload;
                    irq   <= (reload == ZERO);
                end else begin
                    count <= count - ONE;
                    irq   <= (count == ONE);
                end
            end
        end
    end

    assign chan_on = (state_q == S_RUN);

endmodule

// File: rtl/evcnt_regfile.sv
module evcnt_regfile
    import evcnt_pkg::*;
#(
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_we,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    input  logic [DATA_W-1:0] count,
    input  logic              chan_on,
    output logic              unit_on,
    output edge_sel_e         edge_sel,
    output logic              out_en,
    output logic [DATA_W-1:0] reload,
    output logic              start_req,
    output logic              stop_req
);

    logic wr_unit, wr_mode, wr_reload, wr_trig;
    logic start_q, stop_q;

    assign wr_unit   = bus_we && bus_addr == A_UNIT;
    assign wr_mode   = bus_we && bus_addr == A_MODE   && unit_on && !chan_on;
    assign wr_reload = bus_we && bus_addr == A_RELOAD && unit_on;
    assign wr_trig   = bus_we && bus_addr == A_TRIG   && unit_on;

    assign start_req = wr_trig & bus_wdata[0];
    assign stop_req  = wr_trig & bus_wdata[1];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)       unit_on <= 1'b0;
        else if (wr_unit) unit_on <= bus_wdata[0];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            edge_sel <= EDGE_RISE;
            out_en   <= 1'b0;
            reload   <= '0;
            start_q  <= 1'b0;
            stop_q   <= 1'b0;
        end else if (!unit_on) begin
            edge_sel <= EDGE_RISE;
            out_en   <= 1'b0;
            reload   <= '0;
            start_q  <= 1'b0;
            stop_q   <= 1'b0;
        end else begin
            if (wr_mode) begin
                edge_sel <= edge_sel_e'(bus_wdata[1:0]);
                out_en   <= bus_wdata[MODE_OE_BIT];
            end
            if (wr_reload) reload <= bus_wdata;
            start_q <= start_req;
            stop_q  <= stop_req;
        end
    end

    always_comb begin
        bus_rdata = '0;
        unique case (bus_addr)
            A_UNIT:   bus_rdata[0] = unit_on;
            A_MODE: begin
                bus_rdata[1:0]        = edge_sel;
                bus_rdata[MODE_OE_BIT] = out_en;
            end
            A_RELOAD: bus_rdata = reload;
            A_COUNT:  bus_rdata = count;
            A_TRIG:   bus_rdata[1:0] = {stop_q, start_q};
            A_STATUS: bus_rdata[0] = chan_on;
            default:  bus_rdata = '0;
        endcase
    end

endmodule

// File: rtl/evcnt_channel.sv
module evcnt_channel
    import evcnt_pkg::*;
#(
    parameter int DATA_W      = 16,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ev_in,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_we,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    output logic              irq_o
);

    logic              unit_q;
    logic              chan_on;
    logic              start_req;
    logic              stop_req;
    logic              edge_hit;
    logic              out_en;
    edge_sel_e         edge_sel;
    logic [DATA_W-1:0] count_val;
    logic [DATA_W-1:0] reload_val;
    logic [1:0]        mode_val;

    assign mode_val = edge_sel;

    evcnt_regfile #(.DATA_W(DATA_W)) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_addr  (bus_addr),
        .bus_we    (bus_we),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .count     (count_val),
        .chan_on   (chan_on),
        .unit_on   (unit_q),
        .edge_sel  (edge_sel),
        .out_en    (out_en),
        .reload    (reload_val),
        .start_req (start_req),
        .stop_req  (stop_req)
    );

    evcnt_edge_detect #(.SYNC_STAGES(SYNC_STAGES)) u_edge (
        .clk      (clk),
        .rst_n    (rst_n),
        .ev_in    (ev_in),
        .edge_sel (edge_sel),
        .hit      (edge_hit)
    );

    evcnt_ctrl_fsm #(.CNT_W(DATA_W)) u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .unit_on   (unit_q),
        .start_req (start_req),
        .stop_req  (stop_req),
        .hit       (edge_hit),
        .reload    (reload_val),
        .count     (count_val),
        .chan_on   (chan_on),
        .irq       (irq_o)
    );

endmodule

// File: rtl/evcnt_channel_chk.sv
module evcnt_channel_chk #(
    parameter int DATA_W = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic              unit_on,
    input logic              chan_on,
    input logic              start_req,
    input logic              stop_req,
    input logic              hit,
    input logic [DATA_W-1:0] count,
    input logic [DATA_W-1:0] reload,
    input logic [1:0]        mode,
    input logic              irq
);

    // R2: a lone start puts the channel in run with the counter loaded
    p_start_load_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (unit_on && start_req && !stop_req) |=> (chan_on && count == $past(reload)));

    // R3: one decrement per detected event
    p_dec_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (unit_on && chan_on && hit && !start_req && !stop_req && count != '0)
        |=> (count == $past(count) - 1'b1));

    // R4: the interrupt appears only with a zero counter while running
    p_irq_zero_r4: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> (count == '0 && chan_on));

    // R5 and R9: stop always leaves the channel stopped
    p_stop_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (unit_on && stop_req) |=> !chan_on);

    // R5: a stopped channel holds its counter unless started
    p_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (unit_on && !chan_on && !start_req) |=> $stable(count));

    // R7: mode locked while running
    p_mode_lock_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (unit_on && chan_on) |=> $stable(mode));

    // R8: unit disabled clears all channel state
    p_unit_off_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !unit_on |=> (count == '0 && reload == '0 && mode == 2'b00 && !chan_on && !irq));

endmodule

bind evcnt_channel evcnt_channel_chk #(.DATA_W(DATA_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .unit_on   (unit_q),
    .chan_on   (chan_on),
    .start_req (start_req),
    .stop_req  (stop_req),
    .hit       (edge_hit),
    .count     (count_val),
    .reload    (reload_val),
    .mode      (mode_val),
    .irq       (irq_o)
);

// File: tb/evcnt_channel_test.sv
`timescale 1ns/1ps
module evcnt_channel_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        ev_in = 1'b0;
    logic [2:0]  bus_addr = '0;
    logic        bus_we = 1'b0;
    logic [15:0] bus_wdata = '0;
    logic [15:0] bus_rdata;
    logic        irq_o;

    int checks = 0;
    int errors = 0;
    int irq_seen = 0;
    bit done = 0;

    always #5 clk = ~clk;

    evcnt_channel uut (
        .clk       (clk),
        .rst_n     (rst_n),
        .ev_in     (ev_in),
        .bus_addr  (bus_addr),
        .bus_we    (bus_we),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .irq_o     (irq_o)
    );

    always @(negedge clk) if (irq_o) irq_seen++;

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [15:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_we = 1'b1;
        @(negedge clk);
        bus_we = 1'b0;
    endtask

    task automatic rd(input logic [2:0] a, output int v);
        @(negedge clk);
        bus_addr = a;
        #1 v = int'(bus_rdata);
    endtask

    task automatic pulse();
        @(negedge clk); ev_in = 1'b1;
        repeat (5) @(negedge clk);
        ev_in = 1'b0;
        repeat (5) @(negedge clk);
    endtask

    initial begin
        int v;
        int exp_cnt, exp_irq, k;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1: reset state
        for (int a = 0; a < 6; a++) begin
            rd(3'(a), v);
            check("R1", v, 0);
        end
        check("R1", int'(irq_o), 0);

        wr(3'd0, 16'd1);

        // R3/R4 sweep: every edge mode, reload 0..4
        for (int m = 0; m < 3; m++) begin
            for (int n = 0; n < 5; n++) begin
                wr(3'd4, 16'd2);
                wr(3'd1, 16'(m));
                wr(3'd2, 16'(n));
                wr(3'd4, 16'd1);
                rd(3'd5, v);
                check("R2", v, 1);
                rd(3'd4, v);
                check("R2", v, 0);
                rd(3'd3, v);
                check("R2", v, n);
                irq_seen = 0;
                for (int p = 0; p < n + 2; p++) pulse();
                k = (m == 2) ? 2 * (n + 2) : (n + 2);
                exp_cnt = n - (k % (n + 1));
                exp_irq = (k + 1) / (n + 1) - ((n == 0) ? 1 : 0);
                rd(3'd3, v);
                check("R3", v, exp_cnt);
                check("R4", irq_seen, exp_irq);
            end
        end

        // R5: stop freezes the counter
        wr(3'd4, 16'd2);
        wr(3'd1, 16'd0);
        wr(3'd2, 16'd9);
        wr(3'd4, 16'd1);
        pulse(); pulse();
        wr(3'd4, 16'd2);
        rd(3'd5, v);
        check("R5", v, 0);
        pulse(); pulse(); pulse();
        rd(3'd3, v);
        check("R5", v, 7);

        // R9: start and stop together -> stays stopped
        wr(3'd4, 16'd3);
        rd(3'd5, v);
        check("R9", v, 0);
        rd(3'd3, v);
        check("R9", v, 7);

        // R6: reload rewritten while running
        wr(3'd2, 16'd3);
        wr(3'd4, 16'd1);
        pulse(); pulse();
        wr(3'd2, 16'd6);
        rd(3'd3, v);
        check("R6", v, 1);
        pulse(); pulse();
        rd(3'd3, v);
        check("R6", v, 6);

        // R7: mode write ignored while running
        wr(3'd1, 16'h0011);
        rd(3'd1, v);
        check("R7", v, 0);
        pulse();
        rd(3'd3, v);
        check("R7", v, 5);

        // R10: restart while running reloads
        wr(3'd4, 16'd1);
        rd(3'd3, v);
        check("R10", v, 6);
        rd(3'd5, v);
        check("R10", v, 1);

        // R8: unit disable clears and blocks writes
        wr(3'd0, 16'd0);
        repeat (2) @(negedge clk);
        for (int a = 1; a < 6; a++) begin
            rd(3'(a), v);
            check("R8", v, 0);
        end
        wr(3'd2, 16'd5);
        wr(3'd4, 16'd1);
        rd(3'd2, v);
        check("R8", v, 0);
        rd(3'd5, v);
        check("R8", v, 0);
        wr(3'd0, 16'd1);
        rd(3'd2, v);
        check("R8", v, 0);

        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

endmodule